// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches recent virtual-to-physical page translations for a 32-bit address space with 4 KB pages. Every stored translation is compared against the incoming page number at once; there is no set index. The lookup is combinational: in the same cycle the address is presented, the block reports a hit, the physical address (stored frame number followed by the untranslated page offset) and the stored permission bits.

After a miss, the surrounding logic walks the page tables and writes the result through the fill port. A fill first reuses a slot that already holds the same page and process tag. Otherwise it takes the lowest-numbered empty slot. If there is none, it evicts the least recently used translation. Each entry carries the process tag that was current when it was filled. A context switch therefore only changes the current tag, and no flush is needed. A single page can be dropped for every process when its protections change, and a flush empties the whole buffer.

There is no sequencer: state lives in the table registers and the per-entry age counters. Each command takes effect at the rising clock edge where it is sampled.

Top module: `tlb_cache`

## Requirements
- R1: After reset no entry is valid; every lookup misses.
- R2: The page number is address bits [31:12] and the offset is bits [11:0]. On a hit, `lk_paddr` equals {stored frame number, lookup offset} and `lk_perm` equals the stored permissions, in the same cycle as the address.
- R3: On a miss, `lk_hit`, `lk_paddr` and `lk_perm` are all zero.
- R4: An entry hits only when `cur_pid` equals the process tag captured at its fill. Entries with the same page and different tags coexist.
- R5: While any entry is empty, a fill evicts no valid translation. It uses the lowest-indexed empty slot.
- R6: When every entry is valid, a fill of a new translation evicts the least recently used entry.
- R7: A lookup with `lk_valid` high that hits makes that entry the most recent at the clock edge. A lookup with `lk_valid` low never changes recency. A fill makes its entry the most recent.
- R8: A fill whose page and current tag already hit overwrites that entry and creates no second copy.
- R9: `inv_en` removes every entry whose page equals `inv_vpn`, whatever its tag, and leaves all other entries untouched.
- R10: `flush` removes every entry. A fill in the same cycle is discarded.
- R11: At most one entry matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup is a real access; a hit refreshes recency |
| lk_vaddr | input | 32 | Virtual address to translate |
| cur_pid | input | 8 | Current process tag, used for lookup and fill |
| lk_hit | output | 1 | A matching translation exists |
| lk_paddr | output | 32 | Translated physical address, zero on a miss |
| lk_perm | output | 4 | Permission bits of the hit, zero on a miss |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 20 | Page number to write |
| fill_pfn | input | 20 | Frame number to write |
| fill_perm | input | 4 | Permission bits to write |
| inv_en | input | 1 | Drop all entries of one page |
| inv_vpn | input | 20 | Page number to drop |
| flush | input | 1 | Drop all entries |

## Verification
A corrupted age counter appears as the wrong translation disappearing on the first fill into a full buffer. The bench catches it by probing both the expected victim and its neighbour right after that fill. A missed duplicate check or a stale entry surviving an invalidate shows up in the very next lookup: its frame number is the OR of two entries, or a hit is reported where a miss is expected. Probes keep `lk_valid` low, so checking never disturbs the recency order it is measuring.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = 20;
    localparam int PERM_W = 4;
    localparam int PID_W  = 8;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [PID_W-1:0]  pid;
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] perm;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N       = 32,
    parameter bit USE_PID = 1'b1
) (
    input  tlb_entry_t        ents [N],
    input  logic [VPN_W-1:0]  vpn,
    input  logic [PID_W-1:0]  pid,
    output logic [N-1:0]      hit_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        if (USE_PID) begin : g_tagged
            assign hit_vec[g] = ents[g].valid && (ents[g].vpn == vpn) && (ents[g].pid == pid);
        end else begin : g_plain
            logic unused_pid;
            assign unused_pid = ^{ents[g].pid, pid};
            assign hit_vec[g] = ents[g].valid && (ents[g].vpn == vpn);
        end
    end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  valid_vec,
    output logic [IW-1:0] victim_idx
);
    logic [IW-1:0] age [N];
    logic [N-1:0]  oldest_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age[i] <= IW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)       age[i] <= '0;
                else if (age[i] < age[touch_idx]) age[i] <= age[i] + IW'(1);
            end
        end
    end

    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < N; i++) oldest_vec[i] = (age[i] == IW'(N - 1));
        for (int i = N - 1; i >= 0; i--) if (oldest_vec[i]) victim_idx = IW'(i);
        for (int i = N - 1; i >= 0; i--) if (!valid_vec[i]) victim_idx = IW'(i);
    end

    // R6: ages remain a permutation, so exactly one entry is oldest
    a_r6_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);

    // R7: the touched entry is the most recent after the edge
    a_r7_touch_newest: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> age[$past(touch_idx)] == '0);
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
    import tlb_pkg::*;
#(
    parameter int N       = 32,
    parameter bit USE_PID = 1'b1,
    localparam int IW     = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [31:0]       lk_vaddr,
    input  logic [7:0]        cur_pid,
    output logic              lk_hit,
    output logic [31:0]       lk_paddr,
    output logic [3:0]        lk_perm,
    input  logic              fill_en,
    input  logic [19:0]       fill_vpn,
    input  logic [19:0]       fill_pfn,
    input  logic [3:0]        fill_perm,
    input  logic              inv_en,
    input  logic [19:0]       inv_vpn,
    input  logic              flush
);
    tlb_entry_t        tbl [N];
    logic [N-1:0]      valid_vec, lk_vec, fill_vec, inv_vec;
    logic [VPN_W-1:0]  lk_vpn;
    logic [IW-1:0]     lk_idx, fill_idx, victim_idx, fill_slot, touch_idx;
    logic              fill_dup, touch_en;
    logic [PFN_W-1:0]  hit_pfn;
    logic [PERM_W-1:0] hit_perm;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

    tlb_match #(.N(N), .USE_PID(USE_PID)) u_lk_match (
        .ents(tbl), .vpn(lk_vpn), .pid(cur_pid), .hit_vec(lk_vec));

    tlb_match #(.N(N), .USE_PID(USE_PID)) u_fill_match (
        .ents(tbl), .vpn(fill_vpn), .pid(cur_pid), .hit_vec(fill_vec));

    tlb_lru #(.N(N)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
        .valid_vec(valid_vec), .victim_idx(victim_idx));

    always_comb begin
        lk_idx   = '0;
        fill_idx = '0;
        hit_pfn  = '0;
        hit_perm = '0;
        for (int i = 0; i < N; i++) begin
            valid_vec[i] = tbl[i].valid;
            inv_vec[i]   = tbl[i].valid && (tbl[i].vpn == inv_vpn);
            if (lk_vec[i]) begin
                lk_idx   = lk_idx | IW'(i);
                hit_pfn  = hit_pfn | tbl[i].pfn;
                hit_perm = hit_perm | tbl[i].perm;
            end
            if (fill_vec[i]) fill_idx = fill_idx | IW'(i);
        end
        fill_dup  = |fill_vec;
        fill_slot = fill_dup ? fill_idx : victim_idx;
        lk_hit    = |lk_vec;
        lk_paddr  = lk_hit ? {hit_pfn, lk_vaddr[OFF_W-1:0]} : '0;
        lk_perm   = lk_hit ? hit_perm : '0;
    end

    always_comb begin
        touch_en  = 1'b0;
        touch_idx = lk_idx;
        if (!flush) begin
            if (fill_en) begin
                touch_en  = 1'b1;
                touch_idx = fill_slot;
            end else if (lk_valid && lk_hit) begin
                touch_en  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) tbl[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < N; i++) tbl[i].valid <= 1'b0;
        end else begin
            for (int i = 0; i < N; i++) if (inv_en && inv_vec[i]) tbl[i].valid <= 1'b0;
            if (fill_en) tbl[fill_slot] <= '{valid: 1'b1, vpn: fill_vpn, pid: cur_pid,
                                              pfn: fill_pfn, perm: fill_perm};
        end
    end

    // R11: lookup never matches two entries
    a_r11_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));

    // R10: flush leaves nothing valid, even with a fill in the same cycle
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> valid_vec == '0);

    // R5: an accepted fill leaves its chosen slot valid
    a_r5_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> valid_vec[$past(fill_slot)]);

    // R1: right after reset nothing is valid
    a_r1_reset_empty: assert property (@(posedge clk)
        $rose(rst_n) |-> valid_vec == '0);
endmodule

// File: tb/tlb_cache_test.sv
module tlb_cache_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  cur_pid = '0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic [3:0]  lk_perm;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic [3:0]  fill_perm = '0;
    logic        inv_en = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush = 1'b0;

    int n_checks = 0;
    int n_fail = 0;

    tlb_cache uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic probe(input string req, input logic [19:0] vpn, input logic [7:0] pid,
                         input logic exp_hit, input logic [19:0] pfn, input logic [3:0] perm);
        logic [11:0] off;
        off = vpn[11:0] ^ 12'hA5C;
        @(negedge clk);
        lk_valid = 1'b0;
        lk_vaddr = {vpn, off};
        cur_pid  = pid;
        #1;
        chk({req, " hit"}, 32'(lk_hit), 32'(exp_hit));
        chk({req, " paddr"}, lk_paddr, exp_hit ? {pfn, off} : 32'h0);
        chk({req, " perm"}, 32'(lk_perm), exp_hit ? 32'(perm) : 32'h0);
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn,
                           input logic [3:0] perm, input logic [7:0] pid);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm; cur_pid = pid;
        @(posedge clk); #1;
        fill_en = 1'b0;
    endtask

    task automatic do_touch(input logic [19:0] vpn, input logic [7:0] pid);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {vpn, 12'h0}; cur_pid = pid;
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
    endtask

    task automatic fill_full();
        for (int i = 0; i < N; i++) do_fill(20'h00100 + 20'(i), 20'h80000 + 20'(i), 4'(i), 8'd1);
    endtask

    task automatic t_reset();
        probe("R1 reset", 20'h00000, 8'd0, 1'b0, 20'h0, 4'h0);
        probe("R1 reset", 20'h00100, 8'd1, 1'b0, 20'h0, 4'h0);
    endtask

    task automatic t_hit_miss();
        do_fill(20'h12345, 20'hABCDE, 4'h9, 8'd1);
        probe("R2 hit", 20'h12345, 8'd1, 1'b1, 20'hABCDE, 4'h9);
        probe("R3 miss", 20'h12346, 8'd1, 1'b0, 20'h0, 4'h0);
    endtask

    task automatic t_pid();
        do_flush();
        do_fill(20'h00777, 20'h11111, 4'h3, 8'd3);
        probe("R4 own tag", 20'h00777, 8'd3, 1'b1, 20'h11111, 4'h3);
        probe("R4 other tag", 20'h00777, 8'd4, 1'b0, 20'h0, 4'h0);
        do_fill(20'h00777, 20'h22222, 4'h5, 8'd4);
        probe("R4 coexist a", 20'h00777, 8'd3, 1'b1, 20'h11111, 4'h3);
        probe("R4 coexist b", 20'h00777, 8'd4, 1'b1, 20'h22222, 4'h5);
    endtask

    task automatic t_dedup();
        do_flush();
        do_fill(20'h00555, 20'h00F0F, 4'h1, 8'd1);
        do_fill(20'h00555, 20'h0F0F0, 4'h2, 8'd1);
        probe("R8 R11 overwrite", 20'h00555, 8'd1, 1'b1, 20'h0F0F0, 4'h2);
    endtask

    task automatic t_lru_plain();
        do_flush();
        fill_full();
        do_fill(20'h00200, 20'h90000, 4'hE, 8'd1);
        probe("R6 oldest evicted", 20'h00100, 8'd1, 1'b0, 20'h0, 4'h0);
        probe("R6 next kept", 20'h00101, 8'd1, 1'b1, 20'h80001, 4'h1);
        probe("R6 new present", 20'h00200, 8'd1, 1'b1, 20'h90000, 4'hE);
    endtask

    task automatic t_lru_touch();
        do_flush();
        fill_full();
        do_touch(20'h00100, 8'd1);
        do_fill(20'h00200, 20'h90000, 4'hE, 8'd1);
        probe("R7 touched kept", 20'h00100, 8'd1, 1'b1, 20'h80000, 4'h0);
        probe("R7 next evicted", 20'h00101, 8'd1, 1'b0, 20'h0, 4'h0);
    endtask

    task automatic t_free_slot();
        int misses;
        do_flush();
        fill_full();
        @(negedge clk); inv_en = 1'b1; inv_vpn = 20'h00105;
        @(posedge clk); #1; inv_en = 1'b0;
        do_fill(20'h00200, 20'h90000, 4'hE, 8'd1);
        misses = 0;
        for (int i = 0; i < N; i++) begin
            if (i != 5) begin
                @(negedge clk); lk_vaddr = {20'h00100 + 20'(i), 12'h0}; cur_pid = 8'd1; #1;
                if (!lk_hit) misses++;
            end
        end
        chk("R5 no eviction", 32'(misses), 32'd0);
        probe("R5 new present", 20'h00200, 8'd1, 1'b1, 20'h90000, 4'hE);
    endtask

    task automatic t_inv();
        do_flush();
        do_fill(20'h00333, 20'h0AAAA, 4'h1, 8'd3);
        do_fill(20'h00333, 20'h0BBBB, 4'h2, 8'd4);
        do_fill(20'h00444, 20'h0CCCC, 4'h3, 8'd3);
        @(negedge clk); inv_en = 1'b1; inv_vpn = 20'h00333;
        @(posedge clk); #1; inv_en = 1'b0;
        probe("R9 gone tag3", 20'h00333, 8'd3, 1'b0, 20'h0, 4'h0);
        probe("R9 gone tag4", 20'h00333, 8'd4, 1'b0, 20'h0, 4'h0);
        probe("R9 other kept", 20'h00444, 8'd3, 1'b1, 20'h0CCCC, 4'h3);
    endtask

    task automatic t_flush();
        do_fill(20'h00888, 20'h0DDDD, 4'h4, 8'd2);
        @(negedge clk);
        flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h00999; fill_pfn = 20'h0EEEE;
        fill_perm = 4'h6; cur_pid = 8'd2;
        @(posedge clk); #1;
        flush = 1'b0; fill_en = 1'b0;
        probe("R10 old gone", 20'h00888, 8'd2, 1'b0, 20'h0, 4'h0);
        probe("R10 fill dropped", 20'h00999, 8'd2, 1'b0, 20'h0, 4'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_hit_miss();
        t_pid();
        t_dedup();
        t_lru_plain();
        t_lru_touch();
        t_free_slot();
        t_inv();
        t_flush();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule